// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Buffered Compare

This block produces one pulse-width-modulated output from a time-base counter that can run as a triangle (counting up to the period value and back down to zero) or as a sawtooth. An action qualifier watches for the counter reaching the compare value. In triangle mode this happens twice per cycle: once on the rising slope, where it drives the output low, and once on the falling slope, where it drives the output high. The resulting pulse is centred on the zero turning point of the count.

The compare value can be written in two ways. In immediate mode a write replaces the live value on the next clock. In buffered mode a write lands in a holding register, and that register is copied to the live compare only on a selected counter event: zero, period, or either. Because a high pulse straddles the zero turning point, a buffered change that is copied at zero produces one pulse built from half of the old width and half of the new width. A change copied at the period instead produces one mixed low pulse. Designers use the block for dimming-style control, where they need to know exactly which intermediate widths the output will show.

Top module: `updown_pwm`

## Requirements
- R1: With mode_i = 2 the count steps by one each enabled cycle from 0 up to prd_i and back to 0, giving 2·prd_i cycles per PWM period. dir_up_o is 1 when the next step goes up (it is 1 at count 0 and 0 at count prd_i).
- R2: zero_o and prd_o are high for exactly one cycle while the counter is running and the count equals 0 or prd_i respectively, once per PWM period.
- R3: In triangle mode the output is high for 2·C of every 2·prd_i cycles, where C is the live compare value. The output goes low the cycle after the count shows C on the rising slope and goes high the cycle after it shows C on the falling slope.
- R4: A live compare of 0 keeps the output low for the whole period. A live compare of prd_i or more keeps it high for the whole period.
- R5: With mode_i = 0 the count runs 0..prd_i and wraps to 0 (prd_i+1 cycles). The output is high for min(C, prd_i+1) cycles of each period.
- R6: With cmp_imm_i = 0 a write goes only to the holding register. The live compare and the output keep their old behaviour until the selected load event.
- R7: With load_sel_i = 0 (copy at zero; code 3 behaves the same), a buffered change from C0 to C1 gives one high pulse of C0+C1 cycles before the steady 2·C1 pulses.
- R8: With load_sel_i = 1 (copy at period) or 2 (copy at either), a change made on the rising slope gives one low pulse of (prd_i−C0)+(prd_i−C1) cycles, followed by a 2·C1 high pulse.
- R9: With cmp_imm_i = 1 the written value becomes the live compare on the next clock, including in the middle of a slope.
- R10: When a buffered write falls in the same cycle as a load event, the newly written value is the one copied to the live compare at that event.
- R11: With en_i = 0, or mode_i = 1 or 3, the count, direction and output hold, and no event pulses appear.
- R12: Under reset the count is 0, direction is up, the output is low, and both compare registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| prd_i | input | CNT_W | Period value (top of count) |
| mode_i | input | 2 | 0 sawtooth, 2 triangle, 1 and 3 hold |
| cmp_wdata_i | input | CNT_W | Compare write data |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_imm_i | input | 1 | 1 immediate write, 0 buffered write |
| load_sel_i | input | 2 | Buffered copy event: 0 zero, 1 period, 2 either, 3 zero |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | CNT_W | Current count |
| dir_up_o | output | 1 | Next step is upward |
| zero_o | output | 1 | Count-equals-zero pulse |
| prd_o | output | 1 | Count-equals-period pulse |

## Verification
The delicate overlap is a buffered compare write landing in the exact cycle where the counter sits at the selected load event. The holding register and the copy to the live compare then act together. The bench provokes this by waiting until the count reads 0 on the rising side with copy-at-zero selected and strobing the write in that cycle. It then judges the high pulse straddling that zero: it must measure old-plus-new cycles (10 for 2→8 with period 10). If the write missed the copy, the pulse would measure 4. The immediate path is contrasted in a mid-slope write whose next pulse must already be 16 cycles wide.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_SAW    = 2'd0,
    MODE_IDLE_A = 2'd1,
    MODE_TRI    = 2'd2,
    MODE_IDLE_B = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    LOAD_AT_ZERO     = 2'd0,
    LOAD_AT_TOP      = 2'd1,
    LOAD_AT_EITHER   = 2'd2,
    LOAD_AT_ZERO_ALT = 2'd3
  } load_sel_e;

  // Counter advances only in the two counting modes.
  function automatic logic mode_counts(input cnt_mode_e m);
    return (m == MODE_SAW) || (m == MODE_TRI);
  endfunction

  // Decide whether the buffered compare is copied on this cycle's events.
  function automatic logic load_due(input load_sel_e s, input logic at_zero, input logic at_top);
    logic hit;
    case (s)
      LOAD_AT_ZERO:     hit = at_zero;
      LOAD_AT_TOP:      hit = at_top;
      LOAD_AT_EITHER:   hit = at_zero | at_top;
      default:          hit = at_zero;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tri_mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  // Next upward step arrives at (or beyond) the top of count.
  function automatic logic reach_top(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, c} + EXT_W'(1);
    return nxt >= {1'b0, p};
  endfunction

  // Next downward step arrives at zero.
  function automatic logic reach_bottom(input logic [CNT_W-1:0] c);
    return c <= ONE;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (run) begin
      if (tri_mode) begin
        if (prd == '0) begin
          cnt_d = '0;
          dir_d = 1'b1;
        end else if (dir_q) begin
          cnt_d = cnt_q + ONE;
          if (reach_top(cnt_q, prd)) dir_d = 1'b0;
        end else if (cnt_q == '0) begin
          cnt_d = ONE;
          dir_d = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
          if (reach_bottom(cnt_q)) dir_d = 1'b1;
        end
      end else begin
        dir_d = 1'b1;
        cnt_d = (cnt_q >= prd) ? '0 : cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = dir_q;

endmodule

// File: rtl/updown_pwm_cmpbuf.sv
module updown_pwm_cmpbuf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             imm,
  input  logic             load,
  output logic [CNT_W-1:0] cmp_live
);

  logic [CNT_W-1:0] hold_q, hold_d, live_q;

  // A write in the same cycle as a load is what gets copied.
  assign hold_d = we ? wdata : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      live_q <= '0;
    end else begin
      hold_q <= hold_d;
      if (we && imm)        live_q <= wdata;
      else if (load && !imm) live_q <= hold_d;
    end
  end

  assign cmp_live = live_q;

endmodule

// File: rtl/updown_pwm_aq.sv
module updown_pwm_aq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] cmp,
  output logic             up_hit,
  output logic             dn_hit,
  output logic             pwm
);

  logic at_cmp, at_zero, pwm_q;

  assign at_cmp  = (cnt == cmp);
  assign at_zero = (cnt == '0);
  assign up_hit  = run && at_cmp && dir_up;
  assign dn_hit  = run && at_cmp && !dir_up;

  // Rising-slope match wins over the zero set, so a compare of 0 stays low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pwm_q <= 1'b0;
    else if (up_hit)         pwm_q <= 1'b0;
    else if (dn_hit)         pwm_q <= 1'b1;
    else if (run && at_zero) pwm_q <= 1'b1;
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
  import updown_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             cmp_we_i,
  input  logic             cmp_imm_i,
  input  logic [1:0]       load_sel_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_o,
  output logic             prd_o
);

  cnt_mode_e        mode_e;
  load_sel_e        lsel_e;
  logic             running, tri_mode;
  logic [CNT_W-1:0] cnt;
  logic             dir_up;
  logic             zero_evt, top_evt, load_evt;
  logic [CNT_W-1:0] cmp_act;
  logic             up_match, dn_match;

  assign mode_e   = cnt_mode_e'(mode_i);
  assign lsel_e   = load_sel_e'(load_sel_i);
  assign running  = en_i && mode_counts(mode_e);
  assign tri_mode = (mode_e == MODE_TRI);

  updown_pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .tri_mode(tri_mode),
    .prd     (prd_i),
    .cnt     (cnt),
    .dir_up  (dir_up)
  );

  assign zero_evt = running && (cnt == '0);
  assign top_evt  = running && (cnt == prd_i);
  assign load_evt = running && load_due(lsel_e, zero_evt, top_evt);

  updown_pwm_cmpbuf #(.CNT_W(CNT_W)) cb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cmp_we_i),
    .wdata   (cmp_wdata_i),
    .imm     (cmp_imm_i),
    .load    (load_evt),
    .cmp_live(cmp_act)
  );

  updown_pwm_aq #(.CNT_W(CNT_W)) aq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .cnt   (cnt),
    .dir_up(dir_up),
    .cmp   (cmp_act),
    .up_hit(up_match),
    .dn_hit(dn_match),
    .pwm   (pwm_o)
  );

  assign cnt_o    = cnt;
  assign dir_up_o = dir_up;
  assign zero_o   = zero_evt;
  assign prd_o    = top_evt;

endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             tri_mode,
  input logic [CNT_W-1:0] prd_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic             cmp_we_i,
  input logic             cmp_imm_i,
  input logic             load_evt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             up_match,
  input logic             dn_match,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_up_o,
  input logic             zero_o,
  input logic             prd_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_TRI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(running && tri_mode) && running && tri_mode && $stable(prd_i) && prd_i != '0)
      |-> (($past(cnt_o) + ONE == cnt_o) || (cnt_o + ONE == $past(cnt_o)))); // R1

  AST_TOP_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(running && tri_mode) && tri_mode && prd_o && $stable(prd_i) && prd_i != '0)
      |-> !dir_up_o); // R1

  AST_ZERO_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && prd_i != '0) |=> !zero_o); // R2

  AST_TOP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_o && prd_i != '0) |=> (!prd_o || !$stable(prd_i))); // R2

  AST_UP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    up_match |=> !pwm_o); // R3

  AST_DN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_match |=> pwm_o); // R3

  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmp_we_i && cmp_imm_i) && !load_evt) |=> $stable(cmp_act)); // R6

  AST_IMM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && cmp_imm_i) |=> (cmp_act == $past(cmp_wdata_i))); // R9

  AST_SAME_CYCLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cmp_we_i && !cmp_imm_i) |=> (cmp_act == $past(cmp_wdata_i))); // R10

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(cnt_o) && $stable(dir_up_o) && $stable(pwm_o))); // R11

endmodule

bind updown_pwm updown_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .running    (running),
  .tri_mode   (tri_mode),
  .prd_i      (prd_i),
  .cmp_wdata_i(cmp_wdata_i),
  .cmp_we_i   (cmp_we_i),
  .cmp_imm_i  (cmp_imm_i),
  .load_evt   (load_evt),
  .cmp_act    (cmp_act),
  .up_match   (up_match),
  .dn_match   (dn_match),
  .pwm_o      (pwm_o),
  .cnt_o      (cnt_o),
  .dir_up_o   (dir_up_o),
  .zero_o     (zero_o),
  .prd_o      (prd_o)
);

// File: tb/updown_pwm_tb_top.sv
module updown_pwm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] prd;
  logic [1:0]   mode;
  logic [W-1:0] wdata;
  logic         we;
  logic         imm;
  logic [1:0]   lsel;
  logic         pwm;
  logic [W-1:0] cnt;
  logic         dir;
  logic         zev, pev;

  int total = 0;
  int bad = 0;

  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, hi_done = 0, lo_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_pwm #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .prd_i(prd), .mode_i(mode),
    .cmp_wdata_i(wdata), .cmp_we_i(we), .cmp_imm_i(imm), .load_sel_i(lsel),
    .pwm_o(pwm), .cnt_o(cnt), .dir_up_o(dir), .zero_o(zev), .prd_o(pev)
  );

  // Pulse-width monitor, sampling two time units after each rising edge.
  always begin
    @(posedge clk);
    #2;
    if (!rst_n) begin
      hi_run = 0; lo_run = 0;
    end else if (pwm) begin
      hi_run++;
      if (lo_run > 0) begin last_lo = lo_run; lo_done++; lo_run = 0; end
    end else begin
      lo_run++;
      if (hi_run > 0) begin last_hi = hi_run; hi_done++; hi_run = 0; end
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int v);
    wdata = W'(v);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_state(input int c, input bit up);
    do @(negedge clk); while (!(int'(cnt) == c && dir == up));
  endtask

  task automatic setup(input int m, input int p, input int c);
    @(negedge clk);
    imm = 1'b1;
    mode = 2'(m);
    prd = W'(p);
    en = 1'b1;
    wr(c);
    repeat (4 * p + 6) @(negedge clk);
  endtask

  // Buffered change 2 -> 8 at period 10, written on the rising slope at count 1.
  task automatic trans(input int ls, input int exp_lo, input int exp_hi1, input int exp_hi2, input string req);
    int h0, l0;
    setup(2, 10, 2);
    imm = 1'b0;
    lsel = 2'(ls);
    wait_state(1, 1'b1);
    h0 = hi_done; l0 = lo_done;
    wr(8);
    wait (hi_done == h0 + 1);
    chk(last_hi == exp_hi1, "R6 old pulse kept after buffered write", last_hi, exp_hi1);
    wait (lo_done == l0 + 1);
    chk(last_lo == exp_lo, req, last_lo, exp_lo);
    wait (hi_done == h0 + 2);
    chk(last_hi == exp_hi2, req, last_hi, exp_hi2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; prd = W'(10); mode = 2'd2;
    wdata = '0; we = 1'b0; imm = 1'b0; lsel = 2'd0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cnt == '0, "R12 count in reset", int'(cnt), 0);
    chk(dir == 1'b1, "R12 direction in reset", int'(dir), 1);
    chk(pwm == 1'b0, "R12 output in reset", int'(pwm), 0);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    chk(pwm == 1'b0 && zev == 1'b0 && pev == 1'b0, "R12 idle after reset", int'(pwm), 0);
    en = 1'b1;
    repeat (45) @(negedge clk);
    chk(hi_done == 0 && pwm == 1'b0, "R12 compare zero after reset", hi_done, 0);

    // Triangle sweep at period 6 (R1, R2, R3, R4)
    for (int c = 0; c <= 8; c++) begin
      int hi, zc, pc, shape_err, mx;
      int prev;
      setup(2, 6, c);
      hi = 0; zc = 0; pc = 0; shape_err = 0; mx = 0; prev = -1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pwm) hi++;
        if (zev) zc++;
        if (pev) pc++;
        if (int'(cnt) > mx) mx = int'(cnt);
        if (prev >= 0 && !(int'(cnt) == prev + 1 || int'(cnt) == prev - 1)) shape_err++;
        if (int'(cnt) == 0 && dir != 1'b1) shape_err++;
        if (int'(cnt) == 6 && dir != 1'b0) shape_err++;
        prev = int'(cnt);
      end
      chk(shape_err == 0 && mx == 6, "R1 triangle count shape", shape_err, 0);
      chk(zc == 1 && pc == 1, "R2 one zero and one period pulse", zc * 10 + pc, 11);
      if (c == 0 || c >= 6)
        chk(hi == ((c == 0) ? 0 : 12), "R4 saturated compare", hi, (c == 0) ? 0 : 12);
      else
        chk(hi == 2 * c, "R3 triangle high time", hi, 2 * c);
    end

    // Sawtooth sweep at period 5 (R5)
    for (int c = 0; c <= 7; c++) begin
      int hi, zc, pc, exp_hi;
      setup(0, 5, c);
      hi = 0; zc = 0; pc = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (pwm) hi++;
        if (zev) zc++;
        if (pev) pc++;
      end
      exp_hi = (c < 6) ? c : 6;
      chk(hi == exp_hi, "R5 sawtooth high time", hi, exp_hi);
      chk(zc == 1 && pc == 1, "R2 sawtooth event pulses", zc * 10 + pc, 11);
    end

    // Buffered transitions 20% -> 80% style (R6, R7, R8)
    trans(0, 16, 4, 10, "R7 copy at zero mixed pulse");
    trans(3, 16, 4, 10, "R7 code 3 copies at zero");
    trans(1, 10, 4, 16, "R8 copy at period mixed low pulse");
    trans(2, 10, 4, 16, "R8 copy at either event");

    // Write coinciding with the zero load event (R10)
    begin
      int h0;
      setup(2, 10, 2);
      imm = 1'b0;
      lsel = 2'd0;
      wait_state(0, 1'b1);
      h0 = hi_done;
      wr(8);
      wait (hi_done == h0 + 1);
      chk(last_hi == 10, "R10 write at load event is copied", last_hi, 10);
    end

    // Immediate write mid slope (R9)
    begin
      int h0;
      setup(2, 10, 2);
      wait_state(5, 1'b1);
      h0 = hi_done;
      wr(8);
      wait (hi_done == h0 + 1);
      chk(last_hi == 16, "R9 immediate compare takes effect", last_hi, 16);
    end

    // Hold by enable and by idle modes (R11)
    for (int v = 0; v < 3; v++) begin
      logic [W-1:0] c0;
      logic d0, p0;
      int err;
      setup(2, 10, 4);
      repeat (3) @(negedge clk);
      if (v == 0) en = 1'b0;
      else mode = (v == 1) ? 2'd1 : 2'd3;
      c0 = cnt; d0 = dir; p0 = pwm; err = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (cnt != c0 || dir != d0 || pwm != p0 || zev || pev) err++;
      end
      chk(err == 0, "R11 counter and output frozen", err, 0);
      en = 1'b1;
      mode = 2'd2;
    end

    report();
    $finish;
  end

endmodule